// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an age-ordered record of every destination-register rename made by an out-of-order core's rename stage. Each record stores the instruction's sequence number, the architectural register, the physical register just allocated, and the physical register that held the mapping before. An instruction that writes no register leaves a placeholder record that carries only its sequence number. An instruction with several destinations leaves one record per destination, all with the same sequence number.

Two walks empty the buffer, one record per clock. A squash walk starts at the newest record and moves backwards while the record's sequence number is above the squash point. Each real record sends a restore write to the rename map (architectural register back to its previous physical register) and returns the newly allocated register to the free list. A commit walk starts at the oldest record and moves forwards through the committed sequence number. Each real record returns the previous physical register to the free list. Placeholder records are removed by both walks without any register action. The map table and the free list are outside the block and are reached only through the write and return ports.

Top module: `rename_hist_buf`

## Requirements
- R1: A push (`ins_valid`, with `ins_hold`=1 marking a placeholder) is stored at the newest end when the buffer is not busy, not full, and neither `undo_req` nor `retire_req` is high in that cycle. The caller gives non-decreasing sequence numbers.
- R2: After an `undo_req` with sequence S, the block removes one record per cycle from the newest end while that record's sequence is greater than S. For each non-placeholder record it raises `map_we` with `map_areg`=architectural register and `map_preg`=previous physical register, and raises `rel_en` with `rel_preg`=new physical register in the same cycle.
- R3: After a `retire_req` with sequence C, the block removes one record per cycle from the oldest end while that record's sequence is at most C. Each non-placeholder record raises `rel_en` with `rel_preg`=previous physical register and never raises `map_we`.
- R4: Placeholder records are removed by both walks with `map_we` and `rel_en` low.
- R5: A `retire_req` is ignored (`busy` stays low, no record leaves) when the buffer is empty or its oldest sequence is greater than C.
- R6: An `undo_req` on an empty buffer, or one with no newer record, holds `busy` for exactly one cycle and makes no writes.
- R7: An `undo_req` takes priority. When it arrives during a commit walk, no further record is retired and the squash walk follows. A `retire_req` that arrives while busy is ignored.
- R8: `full` is high when the buffer holds DEPTH records and `empty` when it holds none. A push while full is dropped and leaves the contents unchanged.
- R9: `busy` rises in the cycle after an accepted request and stays high for one cycle per removed record plus one closing cycle. Pushes made while busy are dropped.
- R10: After reset the buffer is empty, not full and not busy, with `map_we` and `rel_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Push a record |
| ins_seq | input | SEQ_W | Sequence number of the pushed record |
| ins_areg | input | AREG_W | Architectural register |
| ins_new_preg | input | PREG_W | Newly allocated physical register |
| ins_prev_preg | input | PREG_W | Physical register previously mapped |
| ins_hold | input | 1 | 1 = placeholder record |
| undo_req | input | 1 | Start a squash walk |
| undo_seq | input | SEQ_W | Keep records with sequence at or below this |
| retire_req | input | 1 | Start a commit walk |
| retire_seq | input | SEQ_W | Retire records with sequence at or below this |
| map_we | output | 1 | Restore write to the rename map |
| map_areg | output | AREG_W | Architectural register being restored |
| map_preg | output | PREG_W | Physical register restored into the map |
| rel_en | output | 1 | Return a register to the free list |
| rel_preg | output | PREG_W | Physical register returned |
| busy | output | 1 | A walk is in progress |
| full | output | 1 | Buffer holds DEPTH records |
| empty | output | 1 | Buffer holds no records |

## Verification
The hardest case to reach from the ports is a squash that lands in the middle of a commit walk. The commit has to be stopped after exactly the records already retired, and the squash must then start from the newest end of what is left. The bench starts a commit that covers several records and raises the squash request in the second busy cycle. It also injects a commit request and a push into a running squash walk to show that both are dropped. Random stretches of mixed multi-destination and placeholder pushes, squashes and commits against a fill-limited buffer bring the walks into full and near-empty states that the directed cases do not cover.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  // Walk state shared by the controller and its checks.
  typedef enum logic [1:0] {
    WALK_IDLE   = 2'd0,
    WALK_UNDO   = 2'd1,
    WALK_RETIRE = 2'd2
  } walk_e;
endpackage

// File: rtl/rhb_store.sv
module rhb_store #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [SEQ_W-1:0]  push_seq_i,
  input  logic [AREG_W-1:0] push_areg_i,
  input  logic [PREG_W-1:0] push_new_i,
  input  logic [PREG_W-1:0] push_prev_i,
  input  logic              push_hold_i,
  input  logic              pop_new_i,
  input  logic              pop_old_i,
  output logic              full_o,
  output logic              empty_o,
  output logic [SEQ_W-1:0]  old_seq_o,
  output logic [PREG_W-1:0] old_prev_o,
  output logic              old_hold_o,
  output logic [SEQ_W-1:0]  new_seq_o,
  output logic [AREG_W-1:0] new_areg_o,
  output logic [PREG_W-1:0] new_new_o,
  output logic [PREG_W-1:0] new_prev_o,
  output logic              new_hold_o
);
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int ENT_W  = SEQ_W + AREG_W + 2 * PREG_W + 1;
  // field layout inside one record, lsb first
  localparam int HOLD_B  = 0;
  localparam int PREV_LO = 1;
  localparam int PREV_HI = PREV_LO + PREG_W - 1;
  localparam int NEW_LO  = PREV_HI + 1;
  localparam int NEW_HI  = NEW_LO + PREG_W - 1;
  localparam int AREG_LO = NEW_HI + 1;
  localparam int AREG_HI = AREG_LO + AREG_W - 1;
  localparam int SEQ_LO  = AREG_HI + 1;
  localparam int SEQ_HI  = SEQ_LO + SEQ_W - 1;
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d, newest_idx;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ENT_W-1:0] push_ent;

  assign push_ent   = {push_seq_i, push_areg_i, push_new_i, push_prev_i, push_hold_i};
  assign newest_idx = tail_q - PTR_ONE;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (push_i) begin
      tail_d = tail_q + PTR_ONE;
      cnt_d  = cnt_q + CNT_ONE;
    end else if (pop_new_i) begin
      tail_d = tail_q - PTR_ONE;
      cnt_d  = cnt_q - CNT_ONE;
    end else if (pop_old_i) begin
      head_d = head_q + PTR_ONE;
      cnt_d  = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // record storage: no reset, written only under the push enable
  always_ff @(posedge clk) begin
    if (push_i) begin
      mem_q[tail_q] <= push_ent;
    end
  end

  assign full_o     = (cnt_q == CNT_MAX);
  assign empty_o    = (cnt_q == '0);
  assign old_seq_o  = mem_q[head_q][SEQ_HI:SEQ_LO];
  assign old_prev_o = mem_q[head_q][PREV_HI:PREV_LO];
  assign old_hold_o = mem_q[head_q][HOLD_B];
  assign new_seq_o  = mem_q[newest_idx][SEQ_HI:SEQ_LO];
  assign new_areg_o = mem_q[newest_idx][AREG_HI:AREG_LO];
  assign new_new_o  = mem_q[newest_idx][NEW_HI:NEW_LO];
  assign new_prev_o = mem_q[newest_idx][PREV_HI:PREV_LO];
  assign new_hold_o = mem_q[newest_idx][HOLD_B];

  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R2
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_new_i || pop_old_i) |-> !empty_o);
  // R9
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_i, pop_new_i, pop_old_i}));
  // R8
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> !empty_o);
endmodule

// File: rtl/rhb_walk.sv
module rhb_walk
  import rhb_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             undo_req_i,
  input  logic [SEQ_W-1:0] undo_seq_i,
  input  logic             retire_req_i,
  input  logic [SEQ_W-1:0] retire_seq_i,
  input  logic             empty_i,
  input  logic [SEQ_W-1:0] old_seq_i,
  input  logic [SEQ_W-1:0] new_seq_i,
  output logic             pop_new_o,
  output logic             pop_old_o,
  output logic             busy_o
);
  walk_e            state_q, state_d;
  logic [SEQ_W-1:0] mark_q, mark_d;
  logic             retire_ok;

  // a commit is taken only if the oldest record is already covered
  assign retire_ok = !empty_i && (old_seq_i <= retire_seq_i);

  always_comb begin
    state_d   = state_q;
    mark_d    = mark_q;
    pop_new_o = 1'b0;
    pop_old_o = 1'b0;
    if (undo_req_i) begin
      state_d = WALK_UNDO;
      mark_d  = undo_seq_i;
    end else begin
      case (state_q)
        WALK_IDLE: begin
          if (retire_req_i && retire_ok) begin
            state_d = WALK_RETIRE;
            mark_d  = retire_seq_i;
          end
        end
        WALK_UNDO: begin
          if (!empty_i && (new_seq_i > mark_q)) pop_new_o = 1'b1;
          else                                  state_d   = WALK_IDLE;
        end
        WALK_RETIRE: begin
          if (!empty_i && (old_seq_i <= mark_q)) pop_old_o = 1'b1;
          else                                   state_d   = WALK_IDLE;
        end
        default: state_d = WALK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      mark_q  <= '0;
    end else begin
      state_q <= state_d;
      mark_q  <= mark_d;
    end
  end

  assign busy_o = (state_q != WALK_IDLE);

  // R6
  undo_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undo_req_i |=> busy_o);
  // R5
  retire_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !undo_req_i && retire_req_i && (empty_i || (old_seq_i > retire_seq_i))) |=> !busy_o);
  // R7
  undo_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undo_req_i |-> (!pop_new_o && !pop_old_o));
  // R9
  walk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_new_o || pop_old_o) |-> busy_o);
endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  input  logic [SEQ_W-1:0]  ins_seq,
  input  logic [AREG_W-1:0] ins_areg,
  input  logic [PREG_W-1:0] ins_new_preg,
  input  logic [PREG_W-1:0] ins_prev_preg,
  input  logic              ins_hold,
  input  logic              undo_req,
  input  logic [SEQ_W-1:0]  undo_seq,
  input  logic              retire_req,
  input  logic [SEQ_W-1:0]  retire_seq,
  output logic              map_we,
  output logic [AREG_W-1:0] map_areg,
  output logic [PREG_W-1:0] map_preg,
  output logic              rel_en,
  output logic [PREG_W-1:0] rel_preg,
  output logic              busy,
  output logic              full,
  output logic              empty
);
  logic              push_ok, pop_new, pop_old;
  logic [SEQ_W-1:0]  old_seq, new_seq;
  logic [PREG_W-1:0] old_prev, new_new, new_prev;
  logic [AREG_W-1:0] new_areg;
  logic              old_hold, new_hold;

  assign push_ok = ins_valid && !busy && !full && !undo_req && !retire_req;

  rhb_store #(
    .DEPTH (DEPTH),
    .SEQ_W (SEQ_W),
    .AREG_W(AREG_W),
    .PREG_W(PREG_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_ok),
    .push_seq_i (ins_seq),
    .push_areg_i(ins_areg),
    .push_new_i (ins_new_preg),
    .push_prev_i(ins_prev_preg),
    .push_hold_i(ins_hold),
    .pop_new_i  (pop_new),
    .pop_old_i  (pop_old),
    .full_o     (full),
    .empty_o    (empty),
    .old_seq_o  (old_seq),
    .old_prev_o (old_prev),
    .old_hold_o (old_hold),
    .new_seq_o  (new_seq),
    .new_areg_o (new_areg),
    .new_new_o  (new_new),
    .new_prev_o (new_prev),
    .new_hold_o (new_hold)
  );

  rhb_walk #(
    .SEQ_W(SEQ_W)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .undo_req_i  (undo_req),
    .undo_seq_i  (undo_seq),
    .retire_req_i(retire_req),
    .retire_seq_i(retire_seq),
    .empty_i     (empty),
    .old_seq_i   (old_seq),
    .new_seq_i   (new_seq),
    .pop_new_o   (pop_new),
    .pop_old_o   (pop_old),
    .busy_o      (busy)
  );

  // squash: restore old mapping, free the new register; commit: free the old one
  assign map_we   = pop_new && !new_hold;
  assign map_areg = new_areg;
  assign map_preg = new_prev;
  assign rel_en   = (pop_new && !new_hold) || (pop_old && !old_hold);
  assign rel_preg = pop_new ? new_new : old_prev;

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!map_we && !rel_en));
  // R3
  retire_no_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_old |-> !map_we);
endmodule

// File: tb/rename_hist_buf_test.sv
`timescale 1ns/1ps
module rename_hist_buf_test;
  localparam int DEPTH = 8, SEQ_W = 16, AREG_W = 5, PREG_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              ins_valid = 1'b0, ins_hold = 1'b0;
  logic [SEQ_W-1:0]  ins_seq = '0;
  logic [AREG_W-1:0] ins_areg = '0;
  logic [PREG_W-1:0] ins_new_preg = '0, ins_prev_preg = '0;
  logic              undo_req = 1'b0, retire_req = 1'b0;
  logic [SEQ_W-1:0]  undo_seq = '0, retire_seq = '0;
  logic              map_we, rel_en, busy, full, empty;
  logic [AREG_W-1:0] map_areg;
  logic [PREG_W-1:0] map_preg, rel_preg;

  rename_hist_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_areg(ins_areg),
    .ins_new_preg(ins_new_preg), .ins_prev_preg(ins_prev_preg), .ins_hold(ins_hold),
    .undo_req(undo_req), .undo_seq(undo_seq), .retire_req(retire_req), .retire_seq(retire_seq),
    .map_we(map_we), .map_areg(map_areg), .map_preg(map_preg),
    .rel_en(rel_en), .rel_preg(rel_preg), .busy(busy), .full(full), .empty(empty)
  );

  int checks = 0, fails = 0, next_seq = 1;
  bit done = 1'b0;
  int m_seq[$], m_areg[$], m_new[$], m_prev[$], m_hold[$];
  int e_ma[$], e_mp[$], e_fr[$], o_ma[$], o_mp[$], o_fr[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic flags_chk(input string tag);
    int n = m_seq.size();
    chk(int'(full) == int'(n == DEPTH), {tag, " R8 full"}, int'(full), int'(n == DEPTH));
    chk(int'(empty) == int'(n == 0), {tag, " R8 empty"}, int'(empty), int'(n == 0));
  endtask

  // expected squash outcome: newest first while seq > s
  task automatic model_undo(input int s, output int n);
    n = 0;
    while (m_seq.size() > 0 && m_seq[m_seq.size()-1] > s) begin
      int a = m_areg.pop_back(), nw = m_new.pop_back(), pv = m_prev.pop_back();
      int h = m_hold.pop_back();
      void'(m_seq.pop_back());
      n++;
      if (h == 0) begin
        e_ma.push_back(a); e_mp.push_back(pv); e_fr.push_back(nw);
      end
    end
  endtask

  // expected commit outcome: oldest first while seq <= c, at most lim records
  task automatic model_retire(input int c, input int lim, output int n);
    n = 0;
    while (m_seq.size() > 0 && m_seq[0] <= c && n < lim) begin
      int pv = m_prev.pop_front(), h = m_hold.pop_front();
      void'(m_seq.pop_front()); void'(m_areg.pop_front()); void'(m_new.pop_front());
      n++;
      if (h == 0) e_fr.push_back(pv);
    end
  endtask

  task automatic compare(input string tag);
    chk(o_ma.size() == e_ma.size(), {tag, " R2 map write count"}, o_ma.size(), e_ma.size());
    for (int i = 0; i < o_ma.size() && i < e_ma.size(); i++) begin
      chk(o_ma[i] == e_ma[i], {tag, " R2 map areg"}, o_ma[i], e_ma[i]);
      chk(o_mp[i] == e_mp[i], {tag, " R2 map preg"}, o_mp[i], e_mp[i]);
    end
    chk(o_fr.size() == e_fr.size(), {tag, " R3 release count"}, o_fr.size(), e_fr.size());
    for (int i = 0; i < o_fr.size() && i < e_fr.size(); i++)
      chk(o_fr[i] == e_fr[i], {tag, " R3 release preg"}, o_fr[i], e_fr[i]);
    e_ma.delete(); e_mp.delete(); e_fr.delete();
    o_ma.delete(); o_mp.delete(); o_fr.delete();
  endtask

  // record outputs until busy drops; optional injection (0 squash, 1 commit, 2 push)
  task automatic collect(output int cyc, input int inj_at, input int inj_kind, input int inj_seq);
    bit ended = 1'b0;
    cyc = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      undo_req = 1'b0; retire_req = 1'b0; ins_valid = 1'b0;
      if (i == inj_at) begin
        if (inj_kind == 0) begin undo_req = 1'b1; undo_seq = SEQ_W'(inj_seq); end
        else if (inj_kind == 1) begin retire_req = 1'b1; retire_seq = SEQ_W'(inj_seq); end
        else begin
          ins_valid = 1'b1; ins_seq = SEQ_W'(inj_seq); ins_areg = 5'd7;
          ins_new_preg = 6'd33; ins_prev_preg = 6'd34; ins_hold = 1'b0;
        end
      end
      #1;
      if (!busy) begin
        undo_req = 1'b0; retire_req = 1'b0; ins_valid = 1'b0;
        ended = 1'b1;
        break;
      end
      cyc++;
      if (map_we) begin o_ma.push_back(int'(map_areg)); o_mp.push_back(int'(map_preg)); end
      if (rel_en) o_fr.push_back(int'(rel_preg));
    end
    chk(ended, "R9 walk terminates", 0, 1);
  endtask

  task automatic push_one(input int seq, input int a, input int nw, input int pv, input int h);
    bit acc;
    @(negedge clk);
    acc = (m_seq.size() < DEPTH);
    ins_valid = 1'b1; ins_seq = SEQ_W'(seq); ins_areg = AREG_W'(a);
    ins_new_preg = PREG_W'(nw); ins_prev_preg = PREG_W'(pv); ins_hold = h[0];
    @(negedge clk);
    ins_valid = 1'b0;
    if (acc) begin
      m_seq.push_back(seq); m_areg.push_back(a); m_new.push_back(nw);
      m_prev.push_back(pv); m_hold.push_back(h);
    end
    #1 flags_chk("R1 push");
  endtask

  task automatic push_instr(input int ndest);
    int s = next_seq;
    next_seq++;
    if (ndest == 0) push_one(s, 0, 0, 0, 1);
    else for (int d = 0; d < ndest; d++)
      push_one(s, int'($urandom % 32), int'($urandom % 64), int'($urandom % 64), 0);
  endtask

  task automatic do_undo(input int s, input string tag);
    int n, cyc;
    @(negedge clk);
    undo_req = 1'b1; undo_seq = SEQ_W'(s);
    model_undo(s, n);
    collect(cyc, -1, 0, 0);
    compare(tag);
    chk(cyc == n + 1, {tag, " R9 R6 busy cycles"}, cyc, n + 1);
    flags_chk(tag);
  endtask

  task automatic do_retire(input int c, input string tag);
    int n, cyc, ex;
    bit skip = (m_seq.size() == 0) || (m_seq[0] > c);
    @(negedge clk);
    retire_req = 1'b1; retire_seq = SEQ_W'(c);
    model_retire(c, 1000, n);
    collect(cyc, -1, 0, 0);
    compare(tag);
    ex = skip ? 0 : n + 1;
    chk(cyc == ex, {tag, " R5 R9 busy cycles"}, cyc, ex);
    flags_chk(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int n1, n2, cyc, base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1;
    chk(empty == 1'b1, "R10 reset empty", int'(empty), 1);
    chk(full == 1'b0, "R10 reset full", int'(full), 0);
    chk(busy == 1'b0, "R10 reset busy", int'(busy), 0);
    chk(!map_we && !rel_en, "R10 reset outputs quiet", int'(map_we | rel_en), 0);
    @(negedge clk); rst_n = 1'b1;

    // empty-buffer cases
    do_undo(5, "R6 squash on empty");
    do_retire(5, "R5 commit on empty");

    // mixed records: single, placeholder, two-destination, single
    push_one(1, 3, 10, 1, 0);
    push_one(2, 0, 0, 0, 1);
    push_one(3, 4, 11, 2, 0);
    push_one(3, 5, 12, 6, 0);
    push_one(4, 3, 13, 10, 0);
    next_seq = 5;
    do_retire(0, "R5 commit older than oldest");
    do_retire(1, "R3 commit one");
    do_undo(2, "R2 squash multi-dest newest first");
    do_undo(2, "R6 squash with nothing newer");
    do_retire(2, "R4 placeholder commit");

    // fill to capacity, then one more
    for (int i = 0; i < DEPTH; i++) push_one(10 + i, i, 20 + i, 40 + i, 0);
    chk(full == 1'b1, "R8 full after fill", int'(full), 1);
    push_one(30, 1, 1, 1, 0);
    next_seq = 31;

    // R7: squash lands in the second cycle of a commit walk
    base = m_seq[0];
    @(negedge clk);
    retire_req = 1'b1; retire_seq = SEQ_W'(base + 4);
    model_retire(base + 4, 1, n1);
    model_undo(base + 5, n2);
    collect(cyc, 1, 0, base + 5);
    compare("R7 squash aborts commit");
    flags_chk("R7 abort");

    // R7: commit injected into a squash walk is dropped
    @(negedge clk);
    undo_req = 1'b1; undo_seq = SEQ_W'(base + 2);
    model_undo(base + 2, n1);
    collect(cyc, 0, 1, base + 100);
    compare("R7 commit during squash");
    chk(cyc == n1 + 1, "R7 busy cycles", cyc, n1 + 1);

    // R9: push injected into a squash walk is dropped
    push_one(40, 9, 50, 51, 0);
    push_one(41, 8, 52, 53, 1);
    @(negedge clk);
    undo_req = 1'b1; undo_seq = SEQ_W'(40);
    model_undo(40, n1);
    collect(cyc, 0, 2, 39);
    compare("R9 push during squash");
    do_undo(0, "R9 drain after dropped push");
    next_seq = 42;

    // random mix
    for (int it = 0; it < 400; it++) begin
      int r = int'($urandom % 10);
      if (r < 6) push_instr(int'($urandom % 3));
      else if (r < 8) begin
        int s = next_seq - 1 - int'($urandom % 5);
        if (s < 0) s = 0;
        do_undo(s, "R2 random squash");
      end else begin
        int c = (m_seq.size() > 0) ? m_seq[0] + int'($urandom % 4) - 1 : next_seq;
        do_retire(c, "R3 random commit");
      end
    end
    do_undo(0, "R2 final drain");
    chk(empty == 1'b1, "R8 empty at end", int'(empty), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule